// File: doc/BRIEF.md
# Buffer Descriptor Ring Controller

This block walks a circular ring of buffer descriptors kept in a small on-chip memory. It works for one side (receive or transmit) of a serial channel. Each descriptor takes eight bytes as four halfwords: a status word at offset 0, a length at offset 2, the high half of the buffer pointer at offset 4 and the low half at offset 6. When the channel asks for service, the controller reads the descriptor at its current pointer. If the controller owns that descriptor, it offers the buffer to the data engine. When the engine reports completion, the controller writes the status word and length back and moves to the next entry.

Host software gives the controller the ring's base address and controls it with four commands: immediate stop, graceful stop, restart and close-buffer. In continuous mode the ownership bit is left set on writeback, so the ring cycles with no host action. The close-buffer command returns a partly filled buffer early while the channel keeps running.

Top module: `brc_ring_ctrl`

## Requirements
- R1: After reset the controller is stopped (`stopped`=1). It drives `buf_valid`=0 and `not_ready`=0, and it makes no memory access. A service request has no effect while it is stopped.
- R2: Command code 2 (restart), given while stopped, starts the controller. Each later `svc_req` reads the descriptor halfwords at offsets 0, 2, 4, 6 from the current pointer. The controller then raises `buf_valid` with `buf_len` = halfword 2 and `buf_ptr` = {halfword 4, halfword 6}. Memory reads and writes never occur in the same cycle.
- R3: Status bit 15 is the ownership bit. If a fetched status has bit 15 clear, no buffer is offered and `not_ready` rises. The pointer stays on that entry, and the next `svc_req` polls it again. A later successful fetch clears `not_ready`.
- R4: On `eng_done` in normal mode, the status word is written back with bit 15 cleared and bit 0 cleared. The length halfword becomes `eng_count`. The pointer halfwords are left untouched.
- R5: With `cont_mode`=1 the written-back status keeps bit 15 set. The same descriptors are therefore used again on the next pass with no host write.
- R6: Status bit 14 is the wrap bit. After a descriptor with bit 14 set completes, the next fetch is at the base address. Otherwise the next fetch is at the current address plus 8.
- R7: A base write is accepted only while stopped, and its low three bits are forced to zero. It sets both the base and the current pointer. A base write while running is ignored.
- R8: Command code 0 (stop) sets `stopped` on the next clock and leaves the current descriptor unwritten. A restart then resumes at that same descriptor.
- R9: Command code 1 (graceful stop) given during an active buffer does not stop the controller until that buffer's writeback has finished. Given while idle, it stops the controller within two clocks.
- R10: Command code 3 (close-buffer) during an active buffer writes the status back with bit 0 set and the length = `eng_count`. The pointer advances and the controller keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cont_mode | input | 1 | Continuous mode: keep ownership bit set on writeback |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | AW | New ring base address (bytes) |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 0 stop, 1 graceful stop, 2 restart, 3 close-buffer |
| svc_req | input | 1 | Channel requests the next buffer |
| eng_done | input | 1 | Data engine finished the offered buffer |
| eng_count | input | 16 | Bytes handled in the buffer so far |
| buf_valid | output | 1 | A buffer is offered to the data engine |
| buf_ptr | output | PTR_W | Offered buffer address |
| buf_len | output | 16 | Offered buffer length from the descriptor |
| mem_rd | output | 1 | Descriptor memory read strobe (data next cycle) |
| mem_wr | output | 1 | Descriptor memory write strobe |
| mem_addr | output | AW | Descriptor memory byte address (halfword aligned) |
| mem_wdata | output | 16 | Descriptor memory write data |
| mem_rdata | input | 16 | Descriptor memory read data |
| stopped | output | 1 | Controller is stopped |
| not_ready | output | 1 | Last fetched descriptor was not owned |

## Verification
The bench builds the block with an 8-bit address so that a 128-halfword memory model covers the whole address space. Ring bases at 0 and at 0x48 can then be reached, and a misaligned base write (0x4D) can be checked. The default mask variant of base handling is used, so the forcing of the low bits is observable as fetches at 0x48. A three-entry ring exercises the wrap back to a zero base. A single self-wrapping entry at the non-zero base exercises continuous reuse and a wrap that lands on a non-zero base.

// File: rtl/brc_pkg.sv
package brc_pkg;
   localparam int RDY_BIT    = 15;
   localparam int WRAP_BIT   = 14;
   localparam int CLOSED_BIT = 0;
   localparam int HW         = 16;

   typedef enum logic [1:0] {
      CMD_STOP    = 2'd0,
      CMD_GSTOP   = 2'd1,
      CMD_RESTART = 2'd2,
      CMD_CLOSE   = 2'd3
   } cmd_e;

   typedef enum logic [3:0] {
      S_STOP, S_IDLE, S_F0, S_F1, S_F2, S_F3, S_F4, S_ACT, S_W0, S_W1
   } seq_e;

   typedef struct packed {
      logic stop;
      logic gstop;
      logic restart;
      logic close;
   } cmd_t;
endpackage

// File: rtl/brc_cmd.sv
module brc_cmd
   import brc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_code,
   input  logic       is_stopped,
   output cmd_t       cmd,
   output logic       gstop_pend
);
   always_comb begin
      cmd.stop    = cmd_valid && (cmd_code == CMD_STOP);
      cmd.gstop   = cmd_valid && (cmd_code == CMD_GSTOP);
      cmd.restart = cmd_valid && (cmd_code == CMD_RESTART);
      cmd.close   = cmd_valid && (cmd_code == CMD_CLOSE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      gstop_pend <= 1'b0;
      else if (is_stopped || cmd.stop) gstop_pend <= 1'b0;
      else if (cmd.gstop)              gstop_pend <= 1'b1;
   end

   // R9: a pending graceful stop survives until the controller stops
   assert_gstop_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (gstop_pend && !is_stopped && !cmd.stop) |=> gstop_pend);
endmodule

// File: rtl/brc_ptr.sv
module brc_ptr #(
   parameter int AW        = 12,
   parameter int BASE_MODE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          base_wr,
   input  logic [AW-1:0] base_wdata,
   input  logic          wr_allow,
   input  logic          adv,
   input  logic          adv_wrap,
   output logic [AW-1:0] base_q,
   output logic [AW-1:0] cur_q,
   output logic          take
);
   localparam logic [AW-1:0] STEP = AW'(8);

   logic [AW-1:0] base_aligned;
   logic          base_ok;

   generate
      if (BASE_MODE == 0) begin : g_mask
         assign base_aligned = {base_wdata[AW-1:3], 3'b000};
         assign base_ok      = 1'b1;
      end else begin : g_reject
         assign base_aligned = base_wdata;
         assign base_ok      = (base_wdata[2:0] == 3'b000);
      end
   endgenerate

   assign take = base_wr && wr_allow && base_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (take) begin
         base_q <= base_aligned;
         cur_q  <= base_aligned;
      end else if (adv) begin
         cur_q  <= adv_wrap ? base_q : cur_q + STEP;
      end
   end

   assert_wrap_to_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && adv_wrap && !take) |=> (cur_q == base_q));

   assert_ptr_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cur_q[2:0] == 3'b000);
endmodule

// File: rtl/brc_seq.sv
module brc_seq
   import brc_pkg::*;
#(
   parameter int AW    = 12,
   parameter int PTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cont_mode,
   input  logic             svc_req,
   input  logic             eng_done,
   input  logic [HW-1:0]    eng_count,
   input  cmd_t             cmd,
   input  logic             gstop_pend,
   input  logic             base_taken,
   input  logic [AW-1:0]    cur_q,
   input  logic [HW-1:0]    mem_rdata,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic [AW-1:0]    mem_addr,
   output logic [HW-1:0]    mem_wdata,
   output logic             buf_valid,
   output logic [PTR_W-1:0] buf_ptr,
   output logic [HW-1:0]    buf_len,
   output logic             stopped_o,
   output logic             not_ready_o,
   output logic             adv,
   output logic             adv_wrap
);
   seq_e          state;
   logic [HW-1:0] st_q, len_q, ph_q, pl_q, cnt_q;
   logic          closed_q, nr_q;
   logic [2:0]    off;
   logic [HW-1:0] st_wb;
   logic [31:0]   full_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_STOP;
         st_q     <= '0;
         len_q    <= '0;
         ph_q     <= '0;
         pl_q     <= '0;
         cnt_q    <= '0;
         closed_q <= 1'b0;
         nr_q     <= 1'b0;
      end else begin
         if (base_taken) nr_q <= 1'b0;
         if (cmd.stop && state != S_STOP) begin
            state <= S_STOP;
         end else begin
            case (state)
               S_STOP: if (cmd.restart) state <= S_IDLE;
               S_IDLE: begin
                  if (gstop_pend)   state <= S_STOP;
                  else if (svc_req) state <= S_F0;
               end
               S_F0: state <= S_F1;
               S_F1: begin
                  st_q <= mem_rdata;
                  if (mem_rdata[RDY_BIT]) begin
                     nr_q  <= 1'b0;
                     state <= S_F2;
                  end else begin
                     nr_q  <= 1'b1;
                     state <= S_IDLE;
                  end
               end
               S_F2: begin len_q <= mem_rdata; state <= S_F3; end
               S_F3: begin ph_q  <= mem_rdata; state <= S_F4; end
               S_F4: begin pl_q  <= mem_rdata; state <= S_ACT; end
               S_ACT: begin
                  if (eng_done || cmd.close) begin
                     cnt_q    <= eng_count;
                     closed_q <= !eng_done;
                     state    <= S_W0;
                  end
               end
               S_W0:    state <= S_W1;
               S_W1:    state <= S_IDLE;
               default: state <= S_STOP;
            endcase
         end
      end
   end

   always_comb begin
      st_wb             = st_q;
      st_wb[RDY_BIT]    = cont_mode;
      st_wb[CLOSED_BIT] = closed_q;
   end

   always_comb begin
      off       = 3'd0;
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_wdata = '0;
      case (state)
         S_F0: begin mem_rd = 1'b1; off = 3'd0; end
         S_F1: begin mem_rd = 1'b1; off = 3'd2; end
         S_F2: begin mem_rd = 1'b1; off = 3'd4; end
         S_F3: begin mem_rd = 1'b1; off = 3'd6; end
         S_W0: begin mem_wr = 1'b1; off = 3'd0; mem_wdata = st_wb; end
         S_W1: begin mem_wr = 1'b1; off = 3'd2; mem_wdata = cnt_q; end
         default: ;
      endcase
   end

   assign mem_addr    = cur_q + {{(AW-3){1'b0}}, off};
   assign full_ptr    = {ph_q, pl_q};
   assign buf_ptr     = full_ptr[PTR_W-1:0];
   assign buf_len     = len_q;
   assign buf_valid   = (state == S_ACT);
   assign stopped_o   = (state == S_STOP);
   assign not_ready_o = nr_q;
   assign adv         = (state == S_W1) && !cmd.stop;
   assign adv_wrap    = st_q[WRAP_BIT];

   assert_stall_unowned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_F1 && !mem_rdata[RDY_BIT] && !cmd.stop) |=> (not_ready_o && !buf_valid));

   assert_stop_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.stop |=> stopped_o);

   assert_owner_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && off == 3'd0) |-> (mem_wdata[RDY_BIT] == cont_mode));

   assert_no_rdwr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
endmodule

// File: rtl/brc_ring_ctrl.sv
module brc_ring_ctrl
   import brc_pkg::*;
#(
   parameter int AW        = 12,
   parameter int PTR_W     = 32,
   parameter int BASE_MODE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cont_mode,
   input  logic             base_wr,
   input  logic [AW-1:0]    base_wdata,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_code,
   input  logic             svc_req,
   input  logic             eng_done,
   input  logic [15:0]      eng_count,
   output logic             buf_valid,
   output logic [PTR_W-1:0] buf_ptr,
   output logic [15:0]      buf_len,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic [AW-1:0]    mem_addr,
   output logic [15:0]      mem_wdata,
   input  logic [15:0]      mem_rdata,
   output logic             stopped,
   output logic             not_ready
);
   initial begin
      assert (AW >= 4 && AW <= 16) else $error("AW out of range");
      assert (PTR_W >= 1 && PTR_W <= 32) else $error("PTR_W out of range");
      assert (BASE_MODE == 0 || BASE_MODE == 1) else $error("BASE_MODE must be 0 or 1");
   end

   cmd_t          cmd;
   logic          gstop_pend, take, adv, adv_wrap;
   logic [AW-1:0] base_q, cur_q;

   brc_cmd u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_code   (cmd_code),
      .is_stopped (stopped),
      .cmd        (cmd),
      .gstop_pend (gstop_pend)
   );

   brc_ptr #(.AW(AW), .BASE_MODE(BASE_MODE)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_wr    (base_wr),
      .base_wdata (base_wdata),
      .wr_allow   (stopped),
      .adv        (adv),
      .adv_wrap   (adv_wrap),
      .base_q     (base_q),
      .cur_q      (cur_q),
      .take       (take)
   );

   brc_seq #(.AW(AW), .PTR_W(PTR_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cont_mode   (cont_mode),
      .svc_req     (svc_req),
      .eng_done    (eng_done),
      .eng_count   (eng_count),
      .cmd         (cmd),
      .gstop_pend  (gstop_pend),
      .base_taken  (take),
      .cur_q       (cur_q),
      .mem_rdata   (mem_rdata),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .buf_valid   (buf_valid),
      .buf_ptr     (buf_ptr),
      .buf_len     (buf_len),
      .stopped_o   (stopped),
      .not_ready_o (not_ready),
      .adv         (adv),
      .adv_wrap    (adv_wrap)
   );
endmodule

// File: tb/brc_ring_ctrl_tb.sv
module brc_ring_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cont_mode = 1'b0;
   logic          base_wr = 1'b0;
   logic [AW-1:0] base_wdata = '0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_code = 2'd0;
   logic          svc_req = 1'b0;
   logic          eng_done = 1'b0;
   logic [15:0]   eng_count = '0;
   logic          buf_valid, mem_rd, mem_wr, stopped, not_ready;
   logic [31:0]   buf_ptr;
   logic [15:0]   buf_len, mem_wdata;
   logic [15:0]   mem_rdata = '0;
   logic [AW-1:0] mem_addr;

   logic [15:0] mem [0:127];
   int checks = 0, errors = 0, acc_cnt = 0;
   int exp_cur = 0, exp_base = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   brc_ring_ctrl #(.AW(AW), .PTR_W(32), .BASE_MODE(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .cont_mode(cont_mode),
      .base_wr(base_wr), .base_wdata(base_wdata),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .svc_req(svc_req), .eng_done(eng_done), .eng_count(eng_count),
      .buf_valid(buf_valid), .buf_ptr(buf_ptr), .buf_len(buf_len),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .stopped(stopped), .not_ready(not_ready)
   );

   // descriptor memory model, one cycle read latency
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_addr[AW-1:1]];
      if (mem_wr) mem[mem_addr[AW-1:1]] <= mem_wdata;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-clock comparison against the behavioural model
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd || mem_wr) begin
            acc_cnt++;
            chk("R6 access at model descriptor", 32'(mem_addr >> 3), 32'(exp_cur >> 3));
            chk("R2 no simultaneous rd/wr", 32'(mem_rd && mem_wr), 32'd0);
         end
         if (buf_valid) begin
            chk("R2 buf_len", 32'(buf_len), 32'(mem[(exp_cur+2)/2]));
            chk("R2 buf_ptr", buf_ptr, {mem[(exp_cur+4)/2], mem[(exp_cur+6)/2]});
         end
      end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
   end

   task automatic send_cmd(input logic [1:0] c, input logic [15:0] cnt);
      @(negedge clk); cmd_valid = 1'b1; cmd_code = c; eng_count = cnt;
      @(negedge clk); cmd_valid = 1'b0;
   endtask

   task automatic pulse_svc();
      @(negedge clk); svc_req = 1'b1;
      @(negedge clk); svc_req = 1'b0;
   endtask

   task automatic fetch_ok(input string req);
      pulse_svc();
      for (int i = 0; i < 20 && !buf_valid; i++) @(negedge clk);
      chk(req, 32'(buf_valid), 32'd1);
   endtask

   task automatic set_desc(input int a, input logic [15:0] s, input logic [15:0] l, input logic [31:0] p);
      mem[a/2] = s; mem[a/2+1] = l; mem[a/2+2] = p[31:16]; mem[a/2+3] = p[15:0];
   endtask

   // complete the offered buffer, check writeback, advance model
   task automatic finish_buf(input logic [15:0] cnt, input bit close);
      logic [15:0] orig, exp_st, ph, pl;
      orig = mem[exp_cur/2]; ph = mem[exp_cur/2+2]; pl = mem[exp_cur/2+3];
      if (close) begin
         @(negedge clk); cmd_valid = 1'b1; cmd_code = 2'd3; eng_count = cnt;
         @(negedge clk); cmd_valid = 1'b0;
      end else begin
         @(negedge clk); eng_done = 1'b1; eng_count = cnt;
         @(negedge clk); eng_done = 1'b0;
      end
      repeat (2) @(negedge clk);
      exp_st = orig; exp_st[15] = cont_mode; exp_st[0] = close;
      chk(close ? "R10 status" : (cont_mode ? "R5 status" : "R4 status"), 32'(mem[exp_cur/2]), 32'(exp_st));
      chk(close ? "R10 length" : "R4 length", 32'(mem[exp_cur/2+1]), 32'(cnt));
      chk("R4 pointer words untouched", {mem[exp_cur/2+2], mem[exp_cur/2+3]}, {ph, pl});
      exp_cur = orig[14] ? exp_base : exp_cur + 8;
   endtask

   initial begin
      int acc0;
      for (int i = 0; i < 128; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 stopped after reset", 32'(stopped), 32'd1);
      chk("R1 buf_valid after reset", 32'(buf_valid), 32'd0);
      chk("R1 not_ready after reset", 32'(not_ready), 32'd0);
      acc0 = acc_cnt;
      pulse_svc(); repeat (8) @(negedge clk);
      chk("R1 no access while stopped", 32'(acc_cnt), 32'(acc0));

      // ring of three at base 0, last wraps
      set_desc(0,  16'h8000, 16'h0010, 32'h1111_2222);
      set_desc(8,  16'h8000, 16'h0020, 32'h3333_4444);
      set_desc(16, 16'hC000, 16'h0030, 32'h5555_6666);
      send_cmd(2'd2, 16'd0);
      chk("R2 running after restart", 32'(stopped), 32'd0);
      fetch_ok("R2 offer d0"); finish_buf(16'd7, 1'b0);
      fetch_ok("R2 offer d1"); finish_buf(16'd9, 1'b0);
      fetch_ok("R2 offer d2"); finish_buf(16'd3, 1'b0);
      chk("R6 wrap to base 0", 32'(exp_cur), 32'd0);

      // R3 descriptor 0 now host-owned
      pulse_svc(); repeat (6) @(negedge clk);
      chk("R3 not_ready raised", 32'(not_ready), 32'd1);
      chk("R3 no buffer offered", 32'(buf_valid), 32'd0);
      chk("R3 status untouched", 32'(mem[0]), 32'h0000);
      mem[0] = 16'h8000;
      fetch_ok("R3 re-poll succeeds");
      chk("R3 not_ready cleared", 32'(not_ready), 32'd0);
      // R10 close-buffer
      finish_buf(16'd5, 1'b1);
      chk("R10 still running", 32'(stopped), 32'd0);

      // R8 immediate stop on d1
      mem[4] = 16'h8000;
      fetch_ok("R8 offer d1");
      send_cmd(2'd0, 16'd0);
      chk("R8 stopped next clock", 32'(stopped), 32'd1);
      chk("R8 buffer withdrawn", 32'(buf_valid), 32'd0);
      chk("R8 descriptor unchanged", 32'(mem[4]), 32'h8000);
      send_cmd(2'd2, 16'd0);
      fetch_ok("R8 resume same descriptor"); finish_buf(16'd2, 1'b0);

      // R7 base write while running is ignored
      @(negedge clk); base_wr = 1'b1; base_wdata = 8'h48;
      @(negedge clk); base_wr = 1'b0;
      mem[8] = 16'hC000;
      fetch_ok("R7 ignored base write"); finish_buf(16'd1, 1'b0);
      chk("R6 wrap after d2", 32'(exp_cur), 32'd0);

      // R9 graceful stop during active buffer
      mem[0] = 16'h8000;
      fetch_ok("R9 offer d0");
      send_cmd(2'd1, 16'd0);
      repeat (2) @(negedge clk);
      chk("R9 not stopped while active", 32'(stopped), 32'd0);
      finish_buf(16'd4, 1'b0);
      repeat (2) @(negedge clk);
      chk("R9 stopped after writeback", 32'(stopped), 32'd1);

      // R7 base write while stopped, low bits forced to zero
      @(negedge clk); base_wr = 1'b1; base_wdata = 8'h4D;
      @(negedge clk); base_wr = 1'b0;
      exp_base = 32'h48; exp_cur = 32'h48;
      set_desc(32'h48, 16'hC000, 16'h0040, 32'h7777_8888);

      // R5 continuous mode reuses a self-wrapping entry
      cont_mode = 1'b1;
      send_cmd(2'd2, 16'd0);
      fetch_ok("R7 fetch at new base"); finish_buf(16'd11, 1'b0);
      chk("R6 wrap to non-zero base", 32'(exp_cur), 32'h48);
      fetch_ok("R5 reuse without host"); finish_buf(16'd12, 1'b0);

      // R9 graceful stop while idle
      send_cmd(2'd1, 16'd0);
      repeat (2) @(negedge clk);
      chk("R9 stopped from idle", 32'(stopped), 32'd1);

      summary();
   end
endmodule